// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Host Flag Registers

This block is a full-duplex asynchronous serial port that a host processor drives through four byte-wide register addresses. A mode register picks the character length (7 or 8 bits), turns parity on or off, chooses even or odd parity, and enables the receiver. Each received character is checked for parity and stop-bit errors. When a character completes, it moves into a one-deep receive buffer and a single-cycle interrupt pulse is raised. The host writes bytes for transmission into a one-deep transmit buffer. An idle shifter takes each byte from that buffer and sends it out as a serial frame.

The host reads three sticky error flags: overrun, framing and parity. Reading the error register clears them. Two more flags show whether the transmit buffer still holds a byte and whether the shifter is sending. The bit rate comes from an external strobe at sixteen times the bit rate, which the block counts to find bit boundaries. The serial input is synchronised inside the block, and the external reset is released synchronously.

Top module: `sercom_uart`

## Requirements
- R1: After reset, txd is high, rx_irq is low, and every register address reads 0x00.
- R2: A transmit frame is one low start bit, then the data bits LSB first, then a parity bit when parity is on, then one high stop bit. Each bit lasts 16 baud ticks, and txd stays high whenever no frame is being sent.
- R3: The transmit status register (address 2) has bit 0 = shifter busy and bit 1 = buffer holds a byte not yet taken by the shifter. When the shifter is idle, a byte written to address 3 moves into it on the next clock edge.
- R4: A host write to address 3 while status bit 1 is set is ignored, and that byte is never sent.
- R5: The receiver counts baud ticks from a low level on the synchronised input and checks the line again 8 ticks later. If the line is high at that check, the start is dropped with no error and no interrupt. Data bits are then sampled every 16 ticks.
- R6: A character is copied into the receive buffer (read at address 3) only when its stop bit is high. rx_irq pulses for exactly one cycle at that copy. With 7-bit characters, buffer bit 7 reads 0.
- R7: The expected parity bit is the XOR of the data bits, inverted for odd parity. A mismatch sets error bit 2 (address 1), and the character is still delivered.
- R8: A low stop bit sets error bit 1, leaves the receive buffer unchanged, raises no interrupt, and makes the receiver wait for the line to go high before it looks for a new start bit.
- R9: If a character completes while the previous buffer contents are unread, error bit 0 is set and the buffer takes the new character. Reading address 3 marks the buffer as read.
- R10: Reading address 1 clears all three error flags. An error raised in the same cycle as that read stays set.
- R11: Mode register (address 0) bit 0 enables reception. While it is 0, frames on rxd change no buffer, flag or interrupt.
- R12: The mode register stores and reads back all 8 bits. The fields used are bit 1 = 7-bit characters, bit 2 = parity on, and bit 3 = odd parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | Strobe at 16 times the bit rate |
| host_sel | input | 1 | Register access select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; read side effects happen at the clock edge |
| host_addr | input | 2 | Register address: 0 mode, 1 errors, 2 transmit status, 3 data |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |
| rx_irq | output | 1 | One-cycle receive-complete pulse |

## Verification
Two functions can land on the same clock edge: an error being detected and the host read that clears the error register. The test sends a character with deliberately wrong parity and keeps the error register selected for reading on every cycle, through the whole window in which the stop bit is sampled. The test passes when exactly one of those reads shows the parity flag. This proves the flag was neither lost to the clear nor left standing afterwards. A second overlap, a buffer read against a new arrival, is covered by checking that overrun appears only when the buffer really went unread.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_ERR  = 2'd1;
  localparam logic [1:0] ADDR_TXST = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  typedef struct packed {
    logic [3:0] spare;
    logic       par_odd;
    logic       par_en;
    logic       len7;
    logic       rx_en;
  } mode_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  function automatic logic par_bit(input logic [7:0] d, input logic len7, input logic odd);
    logic p;
    p = len7 ? ^d[6:0] : ^d;
    return p ^ odd;
  endfunction

endpackage

// File: rtl/sercom_sync.sv
module sercom_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RESET_VAL}};
    else        ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic       enable,
  input  logic       len7,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       par_err_o,
  output logic       frm_err_o
);
  localparam int          CW   = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [2:0]    bit_q, bit_n;
  logic [7:0]    sh_q, sh_n;
  logic          perr_q, perr_n;
  logic [2:0]    last_bit;
  logic          bit_end;

  assign last_bit = len7 ? 3'd6 : 3'd7;
  assign bit_end  = tick && (cnt_q == LAST);
  assign data_o   = len7 ? {1'b0, sh_q[7:1]} : sh_q;

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    bit_n     = bit_q;
    sh_n      = sh_q;
    perr_n    = perr_q;
    done_o    = 1'b0;
    par_err_o = 1'b0;
    frm_err_o = 1'b0;
    if (!enable) begin
      st_n  = RX_IDLE;
      cnt_n = '0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (tick && !rxd_s) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt_q == MID) begin
              cnt_n  = '0;
              bit_n  = '0;
              perr_n = 1'b0;
              st_n   = rxd_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt_n = cnt_q + CW'(1);
            end
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_n = '0;
            sh_n  = {rxd_s, sh_q[7:1]};
            bit_n = bit_q + 3'd1;
            if (bit_q == last_bit) st_n = par_en ? RX_PAR : RX_STOP;
          end else if (tick) begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        RX_PAR: begin
          if (bit_end) begin
            cnt_n  = '0;
            perr_n = (rxd_s != par_bit(data_o, len7, par_odd));
            st_n   = RX_STOP;
          end else if (tick) begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt_n = '0;
            if (rxd_s) begin
              done_o    = 1'b1;
              par_err_o = perr_q;
              st_n      = RX_IDLE;
            end else begin
              frm_err_o = 1'b1;
              st_n      = RX_BREAK;
            end
          end else if (tick) begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        RX_BREAK: begin
          if (rxd_s) st_n = RX_IDLE;
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      perr_q <= perr_n;
    end
  end

  // R11: a disabled receiver is parked idle
  assert_rx_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st_q == RX_IDLE));

  // R8: after a bad stop bit nothing is accepted until the line is high
  assert_break_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_BREAK && !rxd_s && enable) |=> (st_q == RX_BREAK));
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
  import sercom_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       len7,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       txd_o,
  output logic       busy_o,
  output logic       full_o
);
  localparam int            CW   = $clog2(OVS);
  localparam int            FW   = 11;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [7:0]    buf_q, buf_n;
  logic          full_q, full_n;
  logic          busy_q, busy_n;
  logic [FW-1:0] sh_q, sh_n, frame;
  logic [3:0]    left_q, left_n, nbits;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          load, accept;

  assign load   = full_q && !busy_q;
  assign accept = wr_i && !full_q;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || !len7) frame[i + 1] = buf_q[i];
    end
    if (par_en) frame[len7 ? 8 : 9] = par_bit(buf_q, len7, par_odd);
    nbits = (len7 ? 4'd9 : 4'd10) + {3'b000, par_en};
  end

  always_comb begin
    buf_n  = buf_q;
    full_n = full_q;
    busy_n = busy_q;
    sh_n   = sh_q;
    left_n = left_q;
    cnt_n  = cnt_q;
    if (accept) begin
      buf_n  = wdata_i;
      full_n = 1'b1;
    end
    if (load) begin
      sh_n   = frame;
      left_n = nbits;
      cnt_n  = '0;
      busy_n = 1'b1;
      full_n = 1'b0;
    end else if (busy_q && tick) begin
      if (cnt_q == LAST) begin
        cnt_n  = '0;
        sh_n   = {1'b1, sh_q[FW-1:1]};
        left_n = left_q - 4'd1;
        if (left_q == 4'd1) busy_n = 1'b0;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (accept) buf_q <= buf_n;
      full_q <= full_n;
      busy_q <= busy_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      cnt_q  <= cnt_n;
    end
  end

  assign txd_o  = sh_q[0];
  assign busy_o = busy_q;
  assign full_o = full_q;

  assert_ignore_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full_q) |=> (buf_q == $past(buf_q)));

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_o);

  assert_load_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && !full_q && !txd_o));
endmodule

// File: rtl/sercom_regs.sv
module sercom_regs
  import sercom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output mode_t      mode_o,
  input  logic       rx_done,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       tx_busy,
  input  logic       tx_full,
  output logic       tx_wr,
  output logic       irq_o
);
  mode_t      mode_q, mode_n;
  logic [2:0] err_q, err_n, err_set;
  logic [7:0] rxbuf_q;
  logic       rxfull_q, rxfull_n;
  logic       irq_q;
  logic       wr_mode, rd_err, rd_data, ovr_set;

  assign wr_mode = sel && wr && (addr == ADDR_MODE);
  assign tx_wr   = sel && wr && (addr == ADDR_DATA);
  assign rd_err  = sel && rd && (addr == ADDR_ERR);
  assign rd_data = sel && rd && (addr == ADDR_DATA);

  always_comb begin
    ovr_set  = rx_done && rxfull_q && !rd_data;
    err_set  = {rx_perr, rx_ferr, ovr_set};
    err_n    = (rd_err ? 3'b000 : err_q) | err_set;
    mode_n   = wr_mode ? mode_t'(wdata) : mode_q;
    rxfull_n = rx_done || (rxfull_q && !rd_data);
  end

  always_comb begin
    rdata = 8'h00;
    if (sel && rd) begin
      case (addr)
        ADDR_MODE: rdata = mode_q;
        ADDR_ERR:  rdata = {5'b0, err_q};
        ADDR_TXST: rdata = {6'b0, tx_full, tx_busy};
        default:   rdata = rxbuf_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      err_q    <= '0;
      rxbuf_q  <= '0;
      rxfull_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_mode) mode_q  <= mode_n;
      if (rx_done) rxbuf_q <= rx_data;
      err_q    <= err_n;
      rxfull_q <= rxfull_n;
      irq_q    <= rx_done;
    end
  end

  assign mode_o = mode_q;
  assign irq_o  = irq_q;

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_msb_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && mode_q.len7) |-> !rxbuf_q[7]);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !rx_done && !rx_ferr) |=> (err_q == 3'b000));

  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rxfull_q && !rd_data) |=> (err_q[0] && irq_q));
endmodule

// File: rtl/sercom_uart.sv
module sercom_uart
  import sercom_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       rx_irq
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       rxd_s;
  mode_t      mode;
  logic       rx_done, rx_perr, rx_ferr;
  logic [7:0] rx_data;
  logic       tx_wr, tx_busy, tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  sercom_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(rxd), .q_o(rxd_s)
  );

  sercom_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .tick(baud_tick), .rxd_s(rxd_s),
    .enable(mode.rx_en), .len7(mode.len7), .par_en(mode.par_en), .par_odd(mode.par_odd),
    .done_o(rx_done), .data_o(rx_data), .par_err_o(rx_perr), .frm_err_o(rx_ferr)
  );

  sercom_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .tick(baud_tick), .wr_i(tx_wr), .wdata_i(host_wdata),
    .len7(mode.len7), .par_en(mode.par_en), .par_odd(mode.par_odd),
    .txd_o(txd), .busy_o(tx_busy), .full_o(tx_full)
  );

  sercom_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .sel(host_sel), .wr(host_wr), .rd(host_rd),
    .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata), .mode_o(mode),
    .rx_done(rx_done), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .tx_busy(tx_busy), .tx_full(tx_full), .tx_wr(tx_wr), .irq_o(rx_irq)
  );
endmodule

// File: tb/sercom_uart_bench.sv
module sercom_uart_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick = 1'b1;
  logic       host_sel, host_wr, host_rd;
  logic [1:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       rxd;
  logic       txd;
  logic       rx_irq;

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;
  int irq_wide = 0;
  bit irq_prev = 1'b0;
  int tx_bits = 10;
  int cap_n = 0;
  logic [10:0] cap [0:15];

  always #5 clk = ~clk;

  sercom_uart u_sercom_uart (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .host_sel(host_sel),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rxd(rxd), .txd(txd),
    .rx_irq(rx_irq)
  );

  always @(negedge clk) begin
    if (rx_irq) begin
      irq_cnt++;
      if (irq_prev) irq_wide++;
    end
    irq_prev = rx_irq;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && txd === 1'b0) begin
        logic [10:0] raw;
        raw = '0;
        repeat (8) @(negedge clk);
        for (int b = 0; b < tx_bits; b++) begin
          repeat (16) @(negedge clk);
          raw[b] = txd;
        end
        if (cap_n < 16) cap[cap_n] = raw;
        cap_n++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 1'b0; host_rd = 1'b0;
  endtask

  function automatic logic calc_par(input logic [7:0] d, input bit len7, input bit odd);
    logic p;
    p = 1'b0;
    for (int i = 0; i < (len7 ? 7 : 8); i++) p ^= d[i];
    return p ^ odd;
  endfunction

  function automatic logic [10:0] exp_raw(input logic [7:0] d, input bit len7, input bit pen, input bit odd);
    logic [10:0] r;
    int dn;
    dn = len7 ? 7 : 8;
    r = '0;
    for (int i = 0; i < dn; i++) r[i] = d[i];
    if (pen) r[dn] = calc_par(d, len7, odd);
    r[dn + (pen ? 1 : 0)] = 1'b1;
    return r;
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit len7, input bit pen,
                            input logic pbit, input logic stopbit);
    @(negedge clk);
    rxd = 1'b0; repeat (16) @(negedge clk);
    for (int i = 0; i < (len7 ? 7 : 8); i++) begin
      rxd = d[i]; repeat (16) @(negedge clk);
    end
    if (pen) begin
      rxd = pbit; repeat (16) @(negedge clk);
    end
    rxd = stopbit; repeat (16) @(negedge clk);
    rxd = 1'b1; repeat (24) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      bus_rd(a[1:0], v);
      chk("R1 register reset value", v, 8'h00);
    end
    chk("R1 txd idle after reset", txd, 1);
    chk("R1 irq low after reset", rx_irq, 0);
  endtask

  task automatic t_mode_rw();
    logic [7:0] v;
    bus_wr(2'd0, 8'hF6);
    bus_rd(2'd0, v);
    chk("R12 mode readback", v, 8'hF6);
    bus_wr(2'd0, 8'h01);
    bus_rd(2'd0, v);
    chk("R12 mode readback 2", v, 8'h01);
  endtask

  task automatic t_rx_basic();
    logic [7:0] v;
    logic [7:0] pats [3] = '{8'hA5, 8'hFF, 8'h00};
    bus_wr(2'd0, 8'h01);
    foreach (pats[i]) begin
      int i0;
      i0 = irq_cnt;
      send_frame(pats[i], 0, 0, 1'b0, 1'b1);
      chk("R6 one irq per character", irq_cnt - i0, 1);
      bus_rd(2'd3, v);
      chk("R6 received byte", v, pats[i]);
      bus_rd(2'd1, v);
      chk("R6 no error on clean frame", v, 0);
    end
    chk("R6 irq pulse width one cycle", irq_wide, 0);
  endtask

  task automatic t_rx_7bit();
    logic [7:0] v;
    bus_wr(2'd0, 8'h07);
    send_frame(8'h31, 1, 1, calc_par(8'h31, 1, 0), 1'b1);
    bus_rd(2'd3, v);
    chk("R6 seven-bit zero-extended", v, 8'h31);
    bus_rd(2'd1, v);
    chk("R7 correct even parity no error", v, 0);
  endtask

  task automatic t_parity_collision();
    logic [7:0] v;
    int i0, hits;
    hits = 0;
    bus_wr(2'd0, 8'h0D);
    i0 = irq_cnt;
    fork
      send_frame(8'h3C, 0, 1, ~calc_par(8'h3C, 0, 1), 1'b1);
      begin
        repeat (150) @(negedge clk);
        host_sel = 1'b1; host_rd = 1'b1; host_addr = 2'd1;
        for (int k = 0; k < 60; k++) begin
          @(negedge clk);
          #1 if (host_rdata[2]) hits++;
        end
        host_sel = 1'b0; host_rd = 1'b0;
      end
    join
    chk("R10 flag set during clearing read survives once", hits, 1);
    bus_rd(2'd1, v);
    chk("R10 flags clear after read", v, 0);
    bus_rd(2'd3, v);
    chk("R7 data delivered despite parity error", v, 8'h3C);
    chk("R7 irq on parity-error character", irq_cnt - i0, 1);
  endtask

  task automatic t_framing();
    logic [7:0] v;
    int i0;
    bus_wr(2'd0, 8'h01);
    i0 = irq_cnt;
    send_frame(8'h77, 0, 0, 1'b0, 1'b0);
    chk("R8 no irq on framing error", irq_cnt - i0, 0);
    bus_rd(2'd1, v);
    chk("R8 framing flag", v, 8'h02);
    bus_rd(2'd3, v);
    chk("R8 buffer unchanged", v, 8'h3C);
    send_frame(8'h11, 0, 0, 1'b0, 1'b1);
    bus_rd(2'd3, v);
    chk("R8 recovery after break", v, 8'h11);
    bus_rd(2'd1, v);
    chk("R8 no spurious error after recovery", v, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    send_frame(8'h12, 0, 0, 1'b0, 1'b1);
    send_frame(8'h34, 0, 0, 1'b0, 1'b1);
    bus_rd(2'd1, v);
    chk("R9 overrun flag", v, 8'h01);
    bus_rd(2'd1, v);
    chk("R10 second read sees cleared flags", v, 0);
    bus_rd(2'd3, v);
    chk("R9 buffer keeps newest", v, 8'h34);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    int i0;
    i0 = irq_cnt;
    @(negedge clk);
    rxd = 1'b0; repeat (3) @(negedge clk);
    rxd = 1'b1; repeat (60) @(negedge clk);
    chk("R5 short low pulse ignored irq", irq_cnt - i0, 0);
    bus_rd(2'd1, v);
    chk("R5 short low pulse no error", v, 0);
    send_frame(8'h5E, 0, 0, 1'b0, 1'b1);
    bus_rd(2'd3, v);
    chk("R5 real frame after glitch", v, 8'h5E);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    int i0;
    bus_wr(2'd0, 8'h00);
    i0 = irq_cnt;
    send_frame(8'h99, 0, 0, 1'b0, 1'b0);
    send_frame(8'h66, 0, 0, 1'b0, 1'b1);
    chk("R11 no irq while disabled", irq_cnt - i0, 0);
    bus_rd(2'd1, v);
    chk("R11 no flags while disabled", v, 0);
    bus_rd(2'd3, v);
    chk("R11 buffer untouched while disabled", v, 8'h5E);
  endtask

  task automatic t_tx(input logic [7:0] mode, input logic [7:0] d);
    logic [7:0] v;
    int c0;
    bit l7, pe, od;
    l7 = mode[1]; pe = mode[2]; od = mode[3];
    tx_bits = (l7 ? 7 : 8) + (pe ? 1 : 0) + 1;
    bus_wr(2'd0, mode);
    c0 = cap_n;
    bus_wr(2'd3, d);
    bus_rd(2'd2, v);
    chk("R3 shifter busy buffer empty", v, 8'h01);
    repeat (200) @(negedge clk);
    chk("R2 one frame sent", cap_n - c0, 1);
    chk("R2 frame bits", cap[c0], exp_raw(d, l7, pe, od));
    bus_rd(2'd2, v);
    chk("R3 idle after frame", v, 8'h00);
    chk("R2 line idles high", txd, 1);
  endtask

  task automatic t_tx_full();
    logic [7:0] v;
    int c0;
    bus_wr(2'd0, 8'h00);
    tx_bits = 9;
    c0 = cap_n;
    bus_wr(2'd3, 8'hA1);
    repeat (2) @(negedge clk);
    bus_wr(2'd3, 8'h5B);
    bus_rd(2'd2, v);
    chk("R3 buffer held while busy", v, 8'h03);
    bus_wr(2'd3, 8'hEE);
    repeat (400) @(negedge clk);
    chk("R4 only two frames sent", cap_n - c0, 2);
    chk("R4 first frame", cap[c0], exp_raw(8'hA1, 0, 0, 0));
    chk("R4 second frame not overwritten", cap[c0 + 1], exp_raw(8'h5B, 0, 0, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0;
    host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_addr = 2'd0; host_wdata = 8'h00;
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode_rw();
    t_rx_basic();
    t_rx_7bit();
    t_parity_collision();
    t_framing();
    t_overrun();
    t_glitch();
    t_disabled();
    t_tx(8'h04, 8'h96);
    t_tx(8'h0E, 8'h4B);
    t_tx(8'h00, 8'hC3);
    t_tx_full();
    report();
  end
endmodule